// File: doc/BRIEF.md
# Watchdog Overflow Reset Controller

This block is the reset-control and status stage of a watchdog timer. It watches a one-cycle overflow pulse from the watchdog's up-counter and a mode input. The mode input selects watchdog operation or interval-timer operation. In watchdog mode, an overflow latches a sticky overflow flag and always sends a one-cycle local reset back to the counter and its control register. If the reset-enable bit is also set, the overflow raises an internal chip-reset output for a fixed number of cycles. In interval mode, an overflow leaves the flag, the chip reset and the local reset untouched, and the reset-enable bit has no effect.

Software reaches one 8-bit control/status register through a simple read/write port. Reads are combinational, and writes take effect at the next clock edge. The flag cannot be cleared by accident. Software must first read the register while the flag is 1, and then write 0 to the flag. A hidden armed bit remembers the qualifying read. The next write uses up the armed bit, and a fresh overflow that arrives before that write cancels it.

Top module: `wdt_rstctl`

## Requirements
- R1: After synchronous reset the register reads 8'h1F (flag bit 7 = 0, enable bit 6 = 0), and chip_rst_o and local_rst_o are low.
- R2: An overflow pulse with mode_wdt = 1 sets the flag (bit 7). It reads as 1 from the cycle after the pulse.
- R3: An overflow pulse with mode_wdt = 0 leaves the flag at 0 and produces neither a chip reset nor a local reset, whatever the enable bit holds.
- R4: A write of 0 to bit 7 that is not preceded by a read returning bit 7 = 1 leaves the flag at 1.
- R5: A read that returns bit 7 = 1, followed by a write with bit 7 = 0, clears the flag. The register reads 0 in bit 7 from the cycle after the write.
- R6: Writing 1 to bit 7 never changes the flag, whether the flag is 0 or 1.
- R7: A watchdog-mode overflow that occurs between the qualifying read and the write cancels the clear, so the flag stays 1.
- R8: A write loads bit 6 of the write data into the enable bit. The new value reads back from the cycle after the write.
- R9: With enable = 1, a watchdog-mode overflow drives chip_rst_o high from the cycle after the pulse for exactly 8 consecutive cycles.
- R10: With enable = 0, a watchdog-mode overflow keeps chip_rst_o low. local_rst_o is high for exactly one cycle, the cycle after the pulse.
- R11: Bit 5 always reads 0 and bits 4..0 always read 1, whatever value was written to them.
- R12: One write uses up a qualifying read. After read(1), write(bit 7 = 1), a second write of 0 leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_pulse | input | 1 | One-cycle overflow strobe from the counter |
| mode_wdt | input | 1 | 1 = watchdog mode, 0 = interval mode |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational register read value |
| chip_rst_o | output | 1 | Internal chip-reset request, stretched pulse |
| local_rst_o | output | 1 | One-cycle reset for the counter and its control register |

## Verification
Every register update and both reset outputs appear one clock edge after the strobe that causes them. The chip-reset pulse then lasts 8 cycles, while the read value follows the register state without delay. The bench drives all strobes and samples all outputs one time unit after the rising edge. A result caused by a strobe is therefore read at the very next sample. The 8-cycle window is measured by counting high samples over twelve consecutive cycles, starting from the first sample after the pulse, which catches both a late start and a wrong length.

// File: rtl/wdt_rstctl_pkg.sv
package wdt_rstctl_pkg;

    localparam int REG_W      = 8;
    localparam int FLAG_POS   = 7;
    localparam int ENA_POS    = 6;
    localparam int ZERO_POS   = 5;
    localparam int ONES_W     = 5;

    typedef struct packed {
        logic flag;
        logic ena;
        logic armed;
        logic lrst;
    } csr_state_t;

endpackage

// File: rtl/wdt_csr_core.sv
module wdt_csr_core
    import wdt_rstctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wdt_ovf,
    input  logic rd,
    input  logic wr,
    input  logic wflag,
    input  logic wena,
    output logic flag,
    output logic ena,
    output logic lrst
);

    csr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.lrst = wdt_ovf;
        if (wr) begin
            st_d.ena   = wena;
            st_d.armed = 1'b0;
            if (st_q.armed && !wflag) begin
                st_d.flag = 1'b0;
            end
        end
        if (rd && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (wdt_ovf) begin
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign ena  = st_q.ena;
    assign lrst = st_q.lrst;

    // R2: watchdog overflow sets the flag
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
        wdt_ovf |=> flag);

    // R6: writing 1 to the flag never clears it
    assert_w1_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (flag && wr && wflag) |=> flag);

    // R4: a write without a qualifying read never clears the flag
    assert_noarm_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (flag && wr && !st_q.armed) |=> flag);

    // R8: enable follows written data
    assert_ena_load_R8: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ena == $past(wena)));

    // R3: no set without a watchdog-mode overflow
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
        (!flag && !wdt_ovf) |=> !flag);

endmodule

// File: rtl/wdt_rst_stretch.sv
module wdt_rst_stretch #(
    parameter int STRETCH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pulse
);

    localparam int CW = $clog2(STRETCH + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(STRETCH);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pulse = (cnt_q != '0);

    // R9: pulse begins the cycle after a start
    assert_pulse_start_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> pulse);

    // R10: without a start an idle output stays idle
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (!pulse && !start) |=> !pulse);

endmodule

// File: rtl/wdt_rstctl.sv
module wdt_rstctl
    import wdt_rstctl_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ovf_pulse,
    input  logic             mode_wdt,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             chip_rst_o,
    output logic             local_rst_o
);

    logic wdt_ovf;
    logic flag, ena;
    logic wdata_unused_bits;

    assign wdt_ovf           = ovf_pulse && mode_wdt;
    assign wdata_unused_bits = ^bus_wdata[ZERO_POS:0];

    wdt_csr_core u_csr (
        .clk   (clk),
        .rst   (rst),
        .wdt_ovf(wdt_ovf),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .wflag (bus_wdata[FLAG_POS]),
        .wena  (bus_wdata[ENA_POS]),
        .flag  (flag),
        .ena   (ena),
        .lrst  (local_rst_o)
    );

    wdt_rst_stretch #(.STRETCH(RST_CYCLES)) u_stretch (
        .clk   (clk),
        .rst   (rst),
        .start (wdt_ovf && ena),
        .pulse (chip_rst_o)
    );

    always_comb begin
        bus_rdata           = '0;
        bus_rdata[FLAG_POS] = flag;
        bus_rdata[ENA_POS]  = ena;
        bus_rdata[ZERO_POS] = 1'b0;
        bus_rdata[ONES_W-1:0] = '1;
    end

    // R3: interval-mode overflow makes no local reset
    assert_interval_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf_pulse && !mode_wdt) |=> !local_rst_o);

    // R10: local reset follows a watchdog overflow for one cycle
    assert_local_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (ovf_pulse && mode_wdt) |=> local_rst_o);

endmodule

// File: tb/wdt_rstctl_bench.sv
module wdt_rstctl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       ovf_pulse, mode_wdt, bus_rd, bus_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       chip_rst_o, local_rst_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_rstctl u_wdt_rstctl (
        .clk(clk), .rst(rst), .ovf_pulse(ovf_pulse), .mode_wdt(mode_wdt),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .chip_rst_o(chip_rst_o), .local_rst_o(local_rst_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        ovf_pulse = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 8'h1F;
    endtask

    task automatic do_reset();
        idle(); mode_wdt = 1; rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    task automatic overflow(input logic m);
        mode_wdt = m; ovf_pulse = 1; tick(); ovf_pulse = 0;
    endtask

    task automatic rd_reg();
        bus_rd = 1; tick(); bus_rd = 0;
    endtask

    task automatic wr_reg(input logic [7:0] d);
        bus_wr = 1; bus_wdata = d; tick(); bus_wr = 0; bus_wdata = 8'h1F;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rdata", bus_rdata, 8'h1F);
        chk("R1 chip_rst", {7'd0, chip_rst_o}, 8'd0);
        chk("R1 local_rst", {7'd0, local_rst_o}, 8'd0);
    endtask

    task automatic t_set_and_noarm();
        do_reset();
        overflow(1);
        chk("R2 flag set", bus_rdata, 8'h9F);
        wr_reg(8'h1F);
        chk("R4 clear without read", bus_rdata, 8'h9F);
        rd_reg();
        wr_reg(8'h1F);
        chk("R5 read then write 0", bus_rdata, 8'h1F);
    endtask

    task automatic t_write_one();
        do_reset();
        wr_reg(8'h80);
        chk("R6 write 1 when clear", bus_rdata[7:7], 1'b0);
        overflow(1);
        rd_reg();
        wr_reg(8'h9F);
        chk("R6 write 1 when set", bus_rdata[7:7], 1'b1);
        wr_reg(8'h1F);
        chk("R12 arm consumed", bus_rdata[7:7], 1'b1);
    endtask

    task automatic t_rearm_cancel();
        do_reset();
        overflow(1);
        rd_reg();
        overflow(1);
        wr_reg(8'h1F);
        chk("R7 overflow cancels clear", bus_rdata[7:7], 1'b1);
    endtask

    task automatic t_interval();
        do_reset();
        wr_reg(8'h40);
        chk("R8 enable set", bus_rdata, 8'h5F);
        overflow(0);
        chk("R3 flag", bus_rdata[7:7], 1'b0);
        chk("R3 chip_rst", {7'd0, chip_rst_o}, 8'd0);
        chk("R3 local_rst", {7'd0, local_rst_o}, 8'd0);
        wr_reg(8'h00);
        chk("R8 enable clear", bus_rdata, 8'h1F);
    endtask

    task automatic t_chip_pulse();
        int hi;
        do_reset();
        wr_reg(8'h40);
        overflow(1);
        chk("R9 first cycle", {7'd0, chip_rst_o}, 8'd1);
        hi = 0;
        for (int i = 0; i < 12; i++) begin
            if (chip_rst_o) hi++;
            tick();
        end
        chk("R9 width", 8'(hi), 8'd8);
    endtask

    task automatic t_no_chip();
        int lo;
        do_reset();
        overflow(1);
        chk("R10 chip_rst low", {7'd0, chip_rst_o}, 8'd0);
        chk("R10 local_rst high", {7'd0, local_rst_o}, 8'd1);
        lo = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (chip_rst_o || local_rst_o) lo++;
        end
        chk("R10 quiet after", 8'(lo), 8'd0);
    endtask

    task automatic t_reserved();
        do_reset();
        wr_reg(8'h20);
        chk("R11 after 0x20", bus_rdata, 8'h1F);
        wr_reg(8'h00);
        chk("R11 after 0x00", bus_rdata, 8'h1F);
    endtask

    initial begin
        idle(); mode_wdt = 1; rst = 1;
        t_reset();
        t_set_and_noarm();
        t_write_one();
        t_rearm_cancel();
        t_interval();
        t_chip_pulse();
        t_no_chip();
        t_reserved();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule